// File: doc/BRIEF.md
# Clocked Serial Position-Encoder Link Master

This block is the host end of a half-duplex, clocked serial link to an absolute position encoder. A single `start` pulse runs one transfer. The block begins toggling the encoder clock and leads in with two zero bit periods. It then shifts out a 6-bit mode word followed by two zero bits, and releases the data line. It keeps clocking until the encoder answers with a start bit, and then shifts in a response of programmable length.

Cable and transceiver delay can exceed half a clock period. To cover this, response bits are not sampled on the transmit rising edge. Each sampling point is the rising edge moved later by `rx_delay` system clocks, and the delay may span several encoder clock periods. If the encoder stays silent for too long, the transfer is abandoned and an error is flagged. The encoder clock half-period is `HALF_DIV` system clocks. The default of 6 gives about 8.3 MHz from a 100 MHz system clock.

Top module: `enc_link_master`

## Requirements
- R1: After reset and between transfers, `enc_clk` is 1, `enc_oe` is 0 and `enc_tx` is 0. `done` and `timeout_err` reset to 0.
- R2: A `start` seen while idle drives `enc_clk` low in the next cycle. The clock then runs with a period of 2*HALF_DIV system clocks, low half first. `enc_tx` changes only at falling edges.
- R3: The first 10 bit periods have `enc_oe`=1. Periods 0 and 1 carry 0. Periods 2 to 7 carry `mode[5]` down to `mode[0]`. Periods 8 and 9 carry 0.
- R4: From period 10 onward, `enc_oe` is 0 and `enc_tx` is 0 while the clock keeps toggling.
- R5: For periods 10 and later, `enc_rx` is captured `rx_delay` system clocks after the first high cycle of that period's clock.
- R6: The first captured 1 is the start bit. The next `rsp_len` captures (1 to MAX_BITS) form `rsp`: the first bit lands in bit `rsp_len`-1, and all bits above it are 0.
- R7: After the last response bit, `done` pulses for one cycle, the clock stops with `enc_clk` high, and `timeout_err` is 0.
- R8: If TO_PER consecutive captures after the command show no start bit, the transfer aborts. `done` pulses, `timeout_err` is 1 and `rsp` is 0. A start bit on capture TO_PER still succeeds.
- R9: `start` is ignored while a transfer runs. `mode`, `rsp_len` and `rx_delay` are taken only at the accepted `start`.
- R10: When `rx_delay` matches the round trip, responses arrive intact even when the round trip is longer than several clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| mode | input | 6 | Mode command bits, sent MSB first |
| rsp_len | input | LEN_W | Response length in bits |
| rx_delay | input | DLY_W | Sample delay in system clocks |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout_err | output | 1 | Last transfer aborted for lack of a start bit |
| rsp | output | MAX_BITS | Received response, first bit most significant |
| enc_clk | output | 1 | Encoder clock, high when idle |
| enc_tx | output | 1 | Data to the encoder |
| enc_oe | output | 1 | Transceiver drive enable |
| enc_rx | input | 1 | Data from the encoder |

## Verification
A behavioural encoder model in the bench sees the clock through a configurable round-trip delay, and the transfers use several delays. One case uses zero delay. Another uses a delay longer than three clock periods, which separates a correctly delayed receive point from one tied to the transmit edge. Three mode patterns are used: all ones, mixed, and sparse. These show whether the bit order and the placement of the lead-in and trailer are right. Response lengths of 1, 5, 24 and the full 32 bits test where the first bit lands. Wait times of zero, TO_PER-1 and TO_PER separate a late-but-valid start bit from a timeout.

// File: rtl/enc_link_master.sv
module enc_link_master #(
  parameter int HALF_DIV = 6,
  parameter int DLY_W    = 6,
  parameter int MAX_BITS = 32,
  parameter int TO_PER   = 100,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [5:0]          mode,
  input  logic [LEN_W-1:0]    rsp_len,
  input  logic [DLY_W-1:0]    rx_delay,
  output logic                done,
  output logic                timeout_err,
  output logic [MAX_BITS-1:0] rsp,
  output logic                enc_clk,
  output logic                enc_tx,
  output logic                enc_oe,
  input  logic                enc_rx
);
  localparam int DLY_N = 1 << DLY_W;
  localparam int HC_W  = $clog2(HALF_DIV + 1);
  localparam int TO_W  = $clog2(TO_PER + 1);
  localparam logic [3:0] CMD_END = 4'd10;

  logic             run, ph, seen;
  logic [HC_W-1:0]  hcnt;
  logic [3:0]       per;
  logic [5:0]       mode_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [DLY_W-1:0] dly_q;
  logic [TO_W-1:0]  wcnt;
  logic [DLY_N-1:0] hist;

  wire       half_end = hcnt == HC_W'(HALF_DIV - 1);
  wire       rise     = run & half_end & ~ph;
  wire       strobe   = run & hist[dly_q];
  wire [9:0] frame    = {2'b00, mode_q, 2'b00};
  wire [3:0] fidx     = 4'd9 - per;
  wire       last_bit = ({1'b0, cnt} + 1'b1) >= {1'b0, len_q};

  assign enc_clk = ~run | ph;
  assign enc_oe  = run & (per < CMD_END);
  assign enc_tx  = enc_oe & frame[fidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; ph <= 1'b0; seen <= 1'b0; hcnt <= '0; per <= '0;
      mode_q <= '0; len_q <= '0; dly_q <= '0; cnt <= '0; wcnt <= '0;
      hist <= '0; rsp <= '0; done <= 1'b0; timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      hist <= {hist[DLY_N-2:0], rise & (per == CMD_END)};
      if (!run) begin
        if (start) begin
          run <= 1'b1; ph <= 1'b0; hcnt <= '0; per <= '0;
          mode_q <= mode; len_q <= rsp_len; dly_q <= rx_delay;
          seen <= 1'b0; cnt <= '0; wcnt <= '0; rsp <= '0;
          timeout_err <= 1'b0; hist <= '0;
        end
      end else begin
        if (half_end) begin
          hcnt <= '0;
          ph   <= ~ph;
          if (ph && per != CMD_END) per <= per + 4'd1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
        if (strobe) begin
          if (!seen) begin
            if (enc_rx) seen <= 1'b1;
            else if (wcnt == TO_W'(TO_PER - 1)) begin
              run <= 1'b0; done <= 1'b1; timeout_err <= 1'b1;
            end else wcnt <= wcnt + 1'b1;
          end else begin
            rsp <= {rsp[MAX_BITS-2:0], enc_rx};
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              run <= 1'b0; done <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_stop_clk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (enc_clk && !enc_oe));
  assert_start_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run) |=> (!enc_clk && enc_oe && !enc_tx));
  assert_tx_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $changed(enc_tx)) |-> !enc_clk);
  assert_oe_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enc_oe) |-> !enc_tx);
endmodule

// File: tb/enc_link_master_tb.sv
module enc_link_master_tb;
  localparam int H = 6;
  localparam int TOP = 20;
  localparam int MB = 32;
  localparam int LW = $clog2(MB + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, enc_rx = 1'b0;
  logic [5:0] mode = '0;
  logic [LW-1:0] rsp_len = '0;
  logic [5:0] rx_delay = '0;
  logic done, timeout_err, enc_clk, enc_tx, enc_oe;
  logic [MB-1:0] rsp;

  enc_link_master #(.HALF_DIV(H), .DLY_W(6), .MAX_BITS(MB), .TO_PER(TOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rsp_len(rsp_len),
    .rx_delay(rx_delay), .done(done), .timeout_err(timeout_err), .rsp(rsp),
    .enc_clk(enc_clk), .enc_tx(enc_tx), .enc_oe(enc_oe), .enc_rx(enc_rx));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int lat = 0, wait_p = 0, nbits = 1;
  logic [31:0] eresp = '0;
  logic [127:0] chist = '1;
  always @(posedge clk) begin
    chist <= {chist[126:0], enc_clk};
    cyc <= cyc + 1;
  end

  int f = 0, hi_cnt = 0;
  logic dprev = 1'b1;
  always @(negedge clk) begin
    logic dc;
    dc = chist[lat];
    if (dprev && !dc) begin
      if (f < 10 + wait_p) enc_rx = 1'b0;
      else if (f == 10 + wait_p) enc_rx = 1'b1;
      else if (f - 11 - wait_p < nbits) enc_rx = eresp[nbits - 1 - (f - 11 - wait_p)];
      else enc_rx = 1'b0;
      f++;
    end
    if (dc) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt > 2 * H + 4) begin f = 0; enc_rx = 1'b0; end
    dprev = dc;
  end

  int ridx = 0, dcnt = 0;
  logic pclk = 1'b1;
  logic tx_at [16];
  logic oe_at [16];
  int rcyc [16];
  always @(negedge clk) begin
    if (enc_clk && !pclk && ridx < 16) begin
      tx_at[ridx] = enc_tx; oe_at[ridx] = enc_oe; rcyc[ridx] = cyc; ridx++;
    end
    pclk = enc_clk;
    if (done) dcnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [5:0] m, input int len, input int d, input int l,
                      input int w, input logic [31:0] r, input bit exp_err,
                      input bit poke, input string req);
    logic [9:0] fr;
    logic [31:0] er;
    bit got;
    lat = l; wait_p = w; nbits = len; eresp = r;
    repeat (l + 40) @(negedge clk);
    ridx = 0; dcnt = 0;
    start = 1'b1; mode = m; rsp_len = LW'(len); rx_delay = 6'(d);
    @(negedge clk);
    start = 1'b0; mode = ~m; rsp_len = LW'(1); rx_delay = 6'd0;
    chk(enc_clk == 1'b0 && enc_oe == 1'b1, "R2", "clock low after start", enc_clk, 0);
    got = 0;
    for (int i = 0; i < 6000 && !got; i++) begin
      if (poke && i == 30) start = 1'b1;
      if (poke && i == 31) start = 1'b0;
      @(negedge clk);
      if (done) got = 1;
    end
    chk(got, req, "done seen", got, 1);
    chk(timeout_err == exp_err, exp_err ? "R8" : "R7", "timeout_err", timeout_err, exp_err);
    er = exp_err ? 32'd0 : ((len == 32) ? r : (r & ((32'd1 << len) - 1)));
    chk(rsp == er, exp_err ? "R8" : "R6", "rsp", rsp, er);
    chk(enc_clk && !enc_oe && !enc_tx, "R7", "clock high at done", enc_clk, 1);
    fr = {2'b00, m, 2'b00};
    for (int k = 0; k < 10; k++) begin
      chk(oe_at[k] == 1'b1, "R3", $sformatf("oe period %0d", k), oe_at[k], 1);
      chk(tx_at[k] == fr[9-k], "R3", $sformatf("tx period %0d", k), tx_at[k], fr[9-k]);
    end
    chk(oe_at[10] == 1'b0 && tx_at[10] == 1'b0, "R4", "line released", oe_at[10], 0);
    chk(rcyc[1] - rcyc[0] == 2 * H, "R2", "clock period", rcyc[1] - rcyc[0], 2 * H);
    repeat (20) @(negedge clk);
    chk(dcnt == 1, poke ? "R9" : "R7", "single done pulse", dcnt, 1);
    chk(enc_clk && !enc_oe, "R1", "idle after transfer", enc_clk, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(enc_clk == 1'b1 && enc_oe == 1'b0 && enc_tx == 1'b0, "R1", "idle lines", enc_clk, 1);
    chk(done == 1'b0 && timeout_err == 1'b0, "R1", "flags", done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(enc_clk == 1'b1 && enc_oe == 1'b0, "R1", "idle after release", enc_clk, 1);
  endtask

  initial begin
    t_reset();
    xfer(6'b111111, 24, 3, 3, 2, 32'h00C3_5A17, 0, 0, "R6");
    xfer(6'b101100, 5, 0, 0, 0, 32'h16, 0, 0, "R5");
    xfer(6'b000111, 32, 40, 40, 5, 32'hA5C3_0F1E, 0, 0, "R10");
    xfer(6'b100001, 8, 8, 8, TOP - 1, 32'h81, 0, 0, "R8");
    xfer(6'b011010, 8, 8, 8, TOP, 32'h81, 1, 0, "R8");
    xfer(6'b010011, 12, 5, 5, 1, 32'hABC, 0, 1, "R9");
    xfer(6'b110101, 1, 2, 2, 3, 32'h1, 0, 0, "R6");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule